// File: doc/BRIEF.md
# Dual-Reference Card Clock Selector

This block turns a requested card clock frequency, given in hertz, into a clock setting. It tries two fixed references, a slow one at 20 MHz and a fast one at 24 MHz. For each reference it finds the smallest integer divider whose output does not exceed the request. It then keeps the reference whose divided output is higher. The result is a 10-bit divider field and a single bit that selects the fast reference.

A request is a target frequency presented together with a one-cycle start strobe. The block then runs a single restoring shift-subtract divider several times in a row. While this happens it holds busy high and keeps its previous setting on the outputs. When the comparison is finished it loads the new setting and raises done for one cycle. The clock generator that consumes the setting, and any switching between references, are outside this block.

Top module: `card_clk_selector`

## Requirements
- R1: After reset, divField is 61, fastSel is 0 (slow reference), busy is 0 and done is 0.
- R2: For each reference, the candidate divider is the integer quotient reference/target, raised to 1 when the quotient is 0. It is increased by one when reference/candidate is still above the target.
- R3: The slow reference is kept (fastSel=0, divField = slow candidate) only when slow/candidate_slow is strictly greater than fast/candidate_fast. Otherwise fastSel=1 and divField = fast candidate, which includes the case where both are equal.
- R4: A target of 0 makes divField 0 (clock stopped) and leaves fastSel at its previous value.
- R5: divField holds only the low 10 bits of the chosen divider (divider AND 0x3FF). For example, a 1 Hz target gives 512.
- R6: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse in the first cycle with busy low.
- R7: A start strobe that arrives while busy is high is ignored. The running request completes with its own result and no second done follows.
- R8: divField and fastSel keep their previous values while busy is high. They change only together with the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startStb | input | 1 | One-cycle request strobe |
| targetHz | input | 32 | Requested card clock in hertz, sampled with startStb |
| divField | output | 10 | Divider setting (0 stops the clock) |
| fastSel | output | 1 | 1 selects the 24 MHz reference, 0 the 20 MHz one |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when a new setting is loaded |

## Verification
The bench builds the block with its default parameters: a 32-bit frequency path, a 10-bit divider field, references of 20 MHz and 24 MHz, and a reset divider of 61. With 32-bit quotients, very low targets such as 1 Hz and 15 kHz produce dividers above 1023, which exercises the 10-bit truncation. The fixed 20/24 MHz pair makes exact ties reachable at 400 kHz and 1 MHz, where the tie must resolve to the fast reference. It also makes cases reachable where the round-up step flips the choice to the slow reference, at 7 MHz and 5 MHz.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  typedef enum logic [1:0] {
    PH_QUOT  = 2'd0,
    PH_CHECK = 2'd1,
    PH_FINAL = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_COMMIT = 2'd3
  } state_e;

  typedef struct packed {
    logic   loadTarget;
    logic   divGo;
    logic   capture;
    logic   commit;
    logic   refSel;
    phase_e phase;
  } ctrl_strobes_t;

  localparam int unsigned NUM_STEPS = 6;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

endpackage

// File: rtl/clksel_shift_divider.sv
module clksel_shift_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0] remR;
  logic [W-1:0] quoR;
  logic [W-1:0] divisorR;
  logic [CNT_W-1:0] cntR;
  logic runningR;
  logic doneR;

  logic [W:0]   trial;
  logic         fits;
  logic [W-1:0] diffLow;

  assign trial   = {remR, quoR[W-1]};
  assign fits    = trial >= {1'b0, divisorR};
  assign diffLow = trial[W-1:0] - divisorR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR     <= '0;
      quoR     <= '0;
      divisorR <= '0;
      cntR     <= '0;
      runningR <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (go) begin
        remR     <= '0;
        quoR     <= dividend;
        divisorR <= divisor;
        cntR     <= CNT_W'(W);
        runningR <= 1'b1;
      end else if (runningR) begin
        remR <= fits ? diffLow : trial[W-1:0];
        quoR <= {quoR[W-2:0], fits};
        cntR <= cntR - 1'b1;
        if (cntR == CNT_W'(1)) begin
          runningR <= 1'b0;
          doneR    <= 1'b1;
        end
      end
    end
  end

  assign quotient = quoR;
  assign done     = doneR;

  // R2: a finished division leaves a remainder below the divisor
  a_r2_remainder_bound: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> (remR < divisorR));

  // R2: no new operands are accepted while a division runs
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    go |-> !runningR);

endmodule

// File: rtl/clksel_datapath.sv
module clksel_datapath
  import clksel_pkg::*;
#(
  parameter int unsigned FREQ_W      = 32,
  parameter int unsigned DIV_W       = 10,
  parameter int unsigned REF_SLOW_HZ = 20_000_000,
  parameter int unsigned REF_FAST_HZ = 24_000_000,
  parameter int unsigned RESET_DIV   = 61
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strb,
  input  logic [FREQ_W-1:0] targetIn,
  output logic              targetInZero,
  output logic              divDone,
  output logic [DIV_W-1:0]  divField,
  output logic              fastSel
);
  localparam logic [FREQ_W-1:0] SLOW_REF = FREQ_W'(REF_SLOW_HZ);
  localparam logic [FREQ_W-1:0] FAST_REF = FREQ_W'(REF_FAST_HZ);
  localparam logic [DIV_W-1:0]  DIV_RST  = DIV_W'(RESET_DIV);
  localparam int unsigned       NUM_REFS = 2;

  logic [FREQ_W-1:0] targetR;
  logic [FREQ_W-1:0] opDividend;
  logic [FREQ_W-1:0] opDivisor;
  logic [FREQ_W-1:0] quot;
  logic [FREQ_W-1:0] candSlow;
  logic [FREQ_W-1:0] candFast;
  logic [FREQ_W-1:0] freqSlow;
  logic [FREQ_W-1:0] freqFast;

  assign targetInZero = (targetIn == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                targetR <= '0;
    else if (strb.loadTarget) targetR <= targetIn;
  end

  for (genvar r = 0; r < NUM_REFS; r++) begin : g_ref
    logic [FREQ_W-1:0] qCand;
    logic [FREQ_W-1:0] gFreq;
    logic              mine;

    assign mine = strb.capture && (strb.refSel == 1'(r));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        qCand <= FREQ_W'(1);
        gFreq <= '0;
      end else if (mine) begin
        case (strb.phase)
          PH_QUOT:  qCand <= (quot == '0) ? FREQ_W'(1) : quot;
          PH_CHECK: if (quot > targetR) qCand <= qCand + 1'b1;
          PH_FINAL: gFreq <= quot;
          default:  ;
        endcase
      end
    end

    // R2: the candidate divider never becomes zero
    a_r2_min_one: assert property (@(posedge clk) disable iff (!rstN)
      (mine && strb.phase == PH_QUOT) |=> (qCand != '0));
  end

  assign candSlow = g_ref[0].qCand;
  assign candFast = g_ref[1].qCand;
  assign freqSlow = g_ref[0].gFreq;
  assign freqFast = g_ref[1].gFreq;

  assign opDividend = strb.refSel ? FAST_REF : SLOW_REF;
  assign opDivisor  = (strb.phase == PH_QUOT) ? targetR
                    : (strb.refSel ? candFast : candSlow);

  clksel_shift_divider #(.W(FREQ_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strb.divGo),
    .dividend (opDividend),
    .divisor  (opDivisor),
    .quotient (quot),
    .done     (divDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divField <= DIV_RST;
      fastSel  <= 1'b0;
    end else if (strb.commit) begin
      if (targetR == '0) begin
        divField <= '0;
      end else if (freqSlow > freqFast) begin
        divField <= candSlow[DIV_W-1:0];
        fastSel  <= 1'b0;
      end else begin
        divField <= candFast[DIV_W-1:0];
        fastSel  <= 1'b1;
      end
    end
  end

  // R4: a zero request stops the clock and keeps the reference choice
  a_r4_zero_stop: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && targetR == '0) |=> (divField == '0 && $stable(fastSel)));

  // R3: equal outputs resolve to the fast reference
  a_r3_tie_fast: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && targetR != '0 && freqSlow == freqFast) |=> fastSel);

  // R3: a strictly faster slow result selects the slow reference
  a_r3_slow_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && targetR != '0 && freqSlow > freqFast) |=> !fastSel);

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startStb,
  input  logic          targetInZero,
  input  logic          divDone,
  output ctrl_strobes_t strb,
  output logic          busy,
  output logic          done
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  state_e            stateR, stateNxt;
  logic [STEP_W-1:0] stepR;
  logic              doneR;

  function automatic logic stepRef(input logic [STEP_W-1:0] s);
    case (s)
      STEP_W'(2), STEP_W'(3), STEP_W'(5): stepRef = 1'b1;
      default:                            stepRef = 1'b0;
    endcase
  endfunction

  function automatic phase_e stepPhase(input logic [STEP_W-1:0] s);
    case (s)
      STEP_W'(0), STEP_W'(2): stepPhase = PH_QUOT;
      STEP_W'(1), STEP_W'(3): stepPhase = PH_CHECK;
      default:                stepPhase = PH_FINAL;
    endcase
  endfunction

  always_comb begin
    strb        = '0;
    strb.refSel = stepRef(stepR);
    strb.phase  = stepPhase(stepR);
    stateNxt    = stateR;
    case (stateR)
      ST_IDLE: begin
        if (startStb) begin
          strb.loadTarget = 1'b1;
          stateNxt        = targetInZero ? ST_COMMIT : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strb.divGo = 1'b1;
        stateNxt   = ST_WAIT;
      end
      ST_WAIT: begin
        if (divDone) begin
          strb.capture = 1'b1;
          stateNxt     = (stepR == LAST_STEP) ? ST_COMMIT : ST_ISSUE;
        end
      end
      ST_COMMIT: begin
        strb.commit = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      stepR  <= '0;
      doneR  <= 1'b0;
    end else begin
      stateR <= stateNxt;
      doneR  <= (stateR == ST_COMMIT);
      if (stateR == ST_IDLE && startStb)
        stepR <= '0;
      else if (stateR == ST_WAIT && divDone && stepR != LAST_STEP)
        stepR <= stepR + 1'b1;
    end
  end

  assign busy = (stateR != ST_IDLE);
  assign done = doneR;

  // R6: each division is launched for exactly one cycle
  a_r6_go_single: assert property (@(posedge clk) disable iff (!rstN)
    strb.divGo |=> !strb.divGo);

  // R7: a start seen while busy does not reload the target
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startStb) |-> !strb.loadTarget);

endmodule

// File: rtl/card_clk_selector.sv
module card_clk_selector
  import clksel_pkg::*;
#(
  parameter int unsigned FREQ_W      = 32,
  parameter int unsigned DIV_W       = 10,
  parameter int unsigned REF_SLOW_HZ = 20_000_000,
  parameter int unsigned REF_FAST_HZ = 24_000_000,
  parameter int unsigned RESET_DIV   = 61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [FREQ_W-1:0] targetHz,
  output logic [DIV_W-1:0]  divField,
  output logic              fastSel,
  output logic              busy,
  output logic              done
);
  ctrl_strobes_t strb;
  logic          targetInZero;
  logic          divDone;

  clksel_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startStb     (startStb),
    .targetInZero (targetInZero),
    .divDone      (divDone),
    .strb         (strb),
    .busy         (busy),
    .done         (done)
  );

  clksel_datapath #(
    .FREQ_W      (FREQ_W),
    .DIV_W       (DIV_W),
    .REF_SLOW_HZ (REF_SLOW_HZ),
    .REF_FAST_HZ (REF_FAST_HZ),
    .RESET_DIV   (RESET_DIV)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .targetIn     (targetHz),
    .targetInZero (targetInZero),
    .divDone      (divDone),
    .divField     (divField),
    .fastSel      (fastSel)
  );

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done marks the first idle cycle after a busy stretch
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R8: the setting is frozen while busy, except at the completing edge
  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (done || ($stable(divField) && $stable(fastSel))));

  // R7: a start during busy neither ends nor restarts the request early
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startStb) |=> (busy || done));

endmodule

// File: tb/sim_card_clk_selector.sv
`timescale 1ns/1ps
module sim_card_clk_selector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0;
  logic [31:0] targetHz = '0;
  logic [9:0]  divField;
  logic        fastSel;
  logic        busy;
  logic        done;

  int errs = 0;
  int checks = 0;

  localparam int REQ_LIMIT = 2000;
  localparam int NVEC = 13;
  localparam int unsigned VEC_TGT [NVEC] = '{
    400000, 25000000, 20000000, 333333, 1000000, 7000000, 1,
    9000000, 5000000, 12000000, 30000, 24000000, 15000 };
  localparam int unsigned VEC_DIV [NVEC] = '{
    60, 1, 1, 72, 24, 3, 512, 3, 4, 2, 800, 1, 576 };
  localparam bit VEC_FAST [NVEC] = '{
    1, 1, 0, 1, 1, 0, 1, 1, 0, 1, 1, 1, 1 };

  always #5 clk = ~clk;

  card_clk_selector u0 (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .targetHz (targetHz),
    .divField (divField),
    .fastSel  (fastSel),
    .busy     (busy),
    .done     (done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runReq(input int unsigned tgt, input int unsigned expDiv,
                        input bit expFast, input string tag);
    logic [9:0] prevDiv;
    logic       prevFast;
    bit         stableOk;
    int         n;
    prevDiv  = divField;
    prevFast = fastSel;
    stableOk = 1'b1;
    n        = 0;
    @(negedge clk);
    targetHz = tgt;
    startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    while (!done && n < REQ_LIMIT) begin
      if (divField != prevDiv || fastSel != prevFast) stableOk = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(n < REQ_LIMIT, "R6 done reached", n, REQ_LIMIT);
    chk(stableOk, "R8 outputs held while busy", int'(stableOk), 1);
    chk(divField == expDiv[9:0], tag, int'(divField), int'(expDiv));
    chk(fastSel == expFast, tag, int'(fastSel), int'(expFast));
    chk(busy == 1'b0, "R6 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single pulse", int'(done), 0);
  endtask

  initial begin
    #1_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(divField == 10'd61, "R1 reset divider", int'(divField), 61);
    chk(fastSel == 1'b0, "R1 reset reference", int'(fastSel), 0);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);

    // R2 R3 R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      runReq(VEC_TGT[i], VEC_DIV[i], VEC_FAST[i], $sformatf("R2 R3 R5 vector %0d", i));
    end

    // R4 zero target after a fast result keeps fast
    runReq(0, 0, 1'b1, "R4 zero keeps fast");
    runReq(7000000, 3, 1'b0, "R3 slow pick");
    // R4 zero target after a slow result keeps slow
    runReq(0, 0, 1'b0, "R4 zero keeps slow");

    // R7 start while busy is ignored
    runReq(9000000, 3, 1'b1, "R7 setup");
    begin
      int n;
      int doneCount;
      n = 0;
      @(negedge clk);
      targetHz = 5000000;
      startStb = 1'b1;
      @(negedge clk);
      startStb = 1'b0;
      repeat (5) @(negedge clk);
      targetHz = 1000000;
      startStb = 1'b1;
      @(negedge clk);
      startStb = 1'b0;
      targetHz = 0;
      while (!done && n < REQ_LIMIT) begin
        @(negedge clk);
        n++;
      end
      chk(divField == 10'd4, "R7 first request result", int'(divField), 4);
      chk(fastSel == 1'b0, "R7 first request reference", int'(fastSel), 0);
      doneCount = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (done || busy) doneCount++;
      end
      chk(doneCount == 0, "R7 no second run", doneCount, 0);
      chk(divField == 10'd4, "R7 setting unchanged", int'(divField), 4);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule